// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Controller

This block turns single internal memory requests into bus cycles on a split external bus. The upper half of a 16-bit address goes out on its own dedicated lines. The lower half shares its pins with the 8-bit data path.

Every machine cycle opens with an address state. In that state the low address byte is driven on the shared lines and a latch strobe is raised, so that an external latch can capture the byte. Once the byte is captured, the shared lines carry data. On a read the block releases the shared lines. On a write it drives the store byte onto them. A slow memory holds its ready input low, and each low sample adds one wait state. When the cycle ends, the block reports completion and, for reads, the captured byte.

A processor core issues opcode fetches, memory reads and memory writes through this block, one request per machine cycle. An instruction that needs several machine cycles simply issues several requests in sequence.

Top module: `mux_bus_ctrl`

## Requirements
- R1: While reset is held and after its release with no request, ale is 0, rdN and wrN are 1, adOe is 0, busIdle is 1 and doneValid is 0.
- R2: A request accepted while busIdle is 1 starts the cycle's first (address) state on the next clock. In that state ale is 1, adOe is 1, adOut holds address bits 7:0 and addrHi holds address bits 15:8.
- R3: ale is high for exactly one state per cycle. In every later state of the cycle ale is 0 and addrHi keeps the value it had in the address state.
- R4: In a read or fetch cycle (reqWrite=0), from the second state to the last, adOe is 0 and rdN is 0. wrN stays 1.
- R5: In a write cycle (reqWrite=1), from the second state to the last, adOe is 1, adOut equals the request's write byte and wrN is 0. rdN stays 1.
- R6: rdy is sampled only at the end of the second state and at the end of each wait state. N consecutive low samples insert exactly N wait states. The value of rdy during the address state and the last state has no effect.
- R7: adIn is captured at the end of the last state of a read. In the following cycle doneValid is 1 for exactly one clock, and doneRData shows the captured byte. A write also raises doneValid for one clock.
- R8: busIdle is 1 only when no cycle is in progress. A request made while busIdle is 0 is ignored and starts no cycle.
- R9: fetchCyc is 1 throughout a cycle requested with reqFetch=1 and reqWrite=0, and 0 otherwise. When both flags are set, the cycle is a write and fetchCyc stays 0.
- R10: A cycle with rdy high takes three bus states. The clock that reports completion may accept the next request, so back-to-back cycles are separated by exactly one idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken when busIdle is 1 |
| reqWrite | input | 1 | 1 = memory write, 0 = read |
| reqFetch | input | 1 | Marks a read as an opcode fetch |
| reqAddr | input | 16 | Request address |
| reqWData | input | 8 | Byte to store on a write |
| busIdle | output | 1 | No cycle in progress |
| doneValid | output | 1 | One-clock completion pulse |
| doneRData | output | 8 | Byte captured by the last read |
| addrHi | output | 8 | Dedicated upper address lines |
| adOut | output | 8 | Shared lines, outgoing value |
| adIn | input | 8 | Shared lines, incoming value |
| adOe | output | 1 | Output enable of the shared lines |
| ale | output | 1 | Address latch strobe |
| rdN | output | 1 | Active-low read strobe |
| wrN | output | 1 | Active-low write strobe |
| rdy | input | 1 | Memory ready |
| fetchCyc | output | 1 | Current cycle is an opcode fetch |

## Verification
A state register that is off by one shows at the pins within a single clock. The latch strobe then appears in a data state, the output enable takes the wrong value, or the strobe pulse is too long or too short. The bench checks every state of every cycle, so such an error is reported in the state where it occurs.

A miscounted wait state shifts the completion pulse by whole clocks. A read sampled at the wrong moment returns the decoy byte that the bench places on adIn before the last state. Both errors show up at the completion of the cycle concerned.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_TW   = 3'd3,
    ST_T3   = 3'd4
  } busState_t;

  typedef struct packed {
    logic loadReq;
    logic addrPhase;
    logic dataPhase;
    logic capture;
  } busStrobe_t;

endpackage

// File: rtl/mbc_control.sv
module mbc_control
  import mbc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       rdy,
  output busStrobe_t strobe,
  output logic       busIdle
);

  busState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE: if (reqValid) nextState = ST_T1;
      ST_T1:   nextState = ST_T2;
      ST_T2:   nextState = rdy ? ST_T3 : ST_TW;
      ST_TW:   nextState = rdy ? ST_T3 : ST_TW;
      ST_T3:   nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe.loadReq   = (state == ST_IDLE) && reqValid;
    strobe.addrPhase = (state == ST_T1);
    strobe.dataPhase = (state == ST_T2) || (state == ST_TW) || (state == ST_T3);
    strobe.capture   = (state == ST_T3);
  end

  assign busIdle = (state == ST_IDLE);

  AST_WAIT_ON_LOW: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_T2 || state == ST_TW) && !rdy) |=> (state == ST_TW)); // R6
  AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (!busIdle && reqValid) |=> !strobe.addrPhase); // R8
  AST_ADDR_THEN_DATA: assert property (@(posedge clk) disable iff (!rstN)
    strobe.addrPhase |=> (strobe.dataPhase && !strobe.addrPhase)); // R3

endmodule

// File: rtl/mbc_datapath.sv
module mbc_datapath
  import mbc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobe_t        strobe,
  input  logic              reqWrite,
  input  logic              reqFetch,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWData,
  output logic              doneValid,
  output logic [DATA_W-1:0] doneRData,
  output logic [ADDR_W-DATA_W-1:0] addrHi,
  output logic [DATA_W-1:0] adOut,
  input  logic [DATA_W-1:0] adIn,
  output logic              adOe,
  output logic              ale,
  output logic              rdN,
  output logic              wrN,
  output logic              fetchCyc
);

  localparam int HI_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] wdataReg;
  logic [DATA_W-1:0] rdataReg;
  logic              isWrite;
  logic              isFetch;
  logic              doneReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg  <= '0;
      wdataReg <= '0;
      isWrite  <= 1'b0;
      isFetch  <= 1'b0;
    end else if (strobe.loadReq) begin
      addrReg  <= reqAddr;
      wdataReg <= reqWData;
      isWrite  <= reqWrite;
      isFetch  <= reqFetch && !reqWrite;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdataReg <= '0;
      doneReg  <= 1'b0;
    end else begin
      doneReg <= strobe.capture;
      if (strobe.capture && !isWrite) rdataReg <= adIn;
    end
  end

  assign addrHi    = addrReg[ADDR_W-1:DATA_W];
  assign adOut     = strobe.addrPhase ? addrReg[DATA_W-1:0] : wdataReg;
  assign adOe      = strobe.addrPhase || (strobe.dataPhase && isWrite);
  assign ale       = strobe.addrPhase;
  assign rdN       = !(strobe.dataPhase && !isWrite);
  assign wrN       = !(strobe.dataPhase && isWrite);
  assign fetchCyc  = (strobe.addrPhase || strobe.dataPhase) && isFetch;
  assign doneValid = doneReg;
  assign doneRData = rdataReg;

  AST_HI_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dataPhase |-> $stable(addrHi)); // R3
  AST_RD_AFTER_ALE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdN) |-> $past(ale)); // R4
  AST_WR_AFTER_ALE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wrN) |-> $past(ale)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid); // R7

  initial begin
    assert (HI_W > 0) else $error("address must be wider than data");
  end

endmodule

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl
  import mbc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqFetch,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWData,
  output logic              busIdle,
  output logic              doneValid,
  output logic [DATA_W-1:0] doneRData,
  output logic [ADDR_W-DATA_W-1:0] addrHi,
  output logic [DATA_W-1:0] adOut,
  input  logic [DATA_W-1:0] adIn,
  output logic              adOe,
  output logic              ale,
  output logic              rdN,
  output logic              wrN,
  input  logic              rdy,
  output logic              fetchCyc
);

  busStrobe_t strobe;

  mbc_control u_control (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .rdy      (rdy),
    .strobe   (strobe),
    .busIdle  (busIdle)
  );

  mbc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqWrite  (reqWrite),
    .reqFetch  (reqFetch),
    .reqAddr   (reqAddr),
    .reqWData  (reqWData),
    .doneValid (doneValid),
    .doneRData (doneRData),
    .addrHi    (addrHi),
    .adOut     (adOut),
    .adIn      (adIn),
    .adOe      (adOe),
    .ale       (ale),
    .rdN       (rdN),
    .wrN       (wrN),
    .fetchCyc  (fetchCyc)
  );

endmodule

// File: tb/sim_mux_bus_ctrl.sv
`timescale 1ns/1ps
module sim_mux_bus_ctrl;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqFetch = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [7:0]  reqWData = '0;
  logic busIdle, doneValid;
  logic [7:0] doneRData, addrHi, adOut;
  logic [7:0] adIn = '0;
  logic adOe, ale, rdN, wrN, fetchCyc;
  logic rdy = 1'b1;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  always #2 clk = ~clk;

  mux_bus_ctrl u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqFetch(reqFetch), .reqAddr(reqAddr), .reqWData(reqWData),
    .busIdle(busIdle), .doneValid(doneValid), .doneRData(doneRData),
    .addrHi(addrHi), .adOut(adOut), .adIn(adIn), .adOe(adOe), .ale(ale),
    .rdN(rdN), .wrN(wrN), .rdy(rdy), .fetchCyc(fetchCyc)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // expected pin word {ale, adOe, rdN, wrN} for a data state
  function automatic logic [3:0] expDataPins(input bit wr);
    return wr ? 4'b0110 : 4'b0011 & 4'b0001 | 4'b0000;
  endfunction

  function automatic bit expFetch(input bit wr, input bit fe);
    return fe && !wr;
  endfunction

  task automatic checkData(input bit wr, input bit fe, input logic [15:0] a,
                           input logic [7:0] wd, input string where);
    logic [3:0] got;
    got = {ale, adOe, rdN, wrN};
    chk(got == expDataPins(wr), wr ? "R5" : "R4", {where, " pins"}, got, expDataPins(wr));
    chk(addrHi == a[15:8], "R3", {where, " addrHi"}, addrHi, a[15:8]);
    if (wr) chk(adOut == wd, "R5", {where, " write byte"}, adOut, wd);
    chk(fetchCyc == expFetch(wr, fe), "R9", {where, " fetchCyc"}, fetchCyc, expFetch(wr, fe));
    chk(busIdle == 1'b0, "R8", {where, " busIdle"}, busIdle, 0);
  endtask

  // called at a negedge with the bus idle; returns at the negedge of the done cycle
  task automatic runCycle(input bit wr, input bit fe, input logic [15:0] a,
                          input logic [7:0] wd, input logic [7:0] rd,
                          input int nWait, input bit junk);
    reqValid = 1'b1; reqWrite = wr; reqFetch = fe; reqAddr = a; reqWData = wd;
    rdy = 1'b0; adIn = ~rd;
    @(posedge clk); @(negedge clk);
    reqValid = 1'b0; reqAddr = ~a; reqWData = ~wd;
    chk(ale && adOe, "R2", "address state ale/adOe", {ale, adOe}, 2'b11);
    chk(adOut == a[7:0], "R2", "low address", adOut, a[7:0]);
    chk(addrHi == a[15:8], "R2", "high address", addrHi, a[15:8]);
    chk(rdN && wrN, "R2", "strobes idle in T1", {rdN, wrN}, 2'b11);
    chk(doneValid == 1'b0, "R7", "done cleared in T1", doneValid, 0);
    chk(fetchCyc == expFetch(wr, fe), "R9", "fetchCyc T1", fetchCyc, expFetch(wr, fe));
    rdy = 1'b0;                       // ignored at end of T1 (R6)
    @(posedge clk); @(negedge clk);
    checkData(wr, fe, a, wd, "T2");
    if (junk) begin reqValid = 1'b1; reqAddr = a ^ 16'h5a5a; end
    rdy = (nWait == 0);
    for (int i = 1; i <= nWait; i++) begin
      @(posedge clk); @(negedge clk);
      checkData(wr, fe, a, wd, "wait");
      rdy = (i == nWait);
    end
    @(posedge clk); @(negedge clk);
    checkData(wr, fe, a, wd, "T3");
    adIn = rd;  rdy = 1'b0;           // rdy ignored in T3 (R6)
    @(posedge clk); @(negedge clk);
    chk(doneValid == 1'b1, "R6", "done after N waits", doneValid, 1);
    if (!wr) chk(doneRData == rd, "R7", "read byte", doneRData, rd);
    chk({ale, adOe, rdN, wrN} == 4'b0011, "R10", "idle pins after cycle", {ale, adOe, rdN, wrN}, 4'b0011);
    chk(busIdle == 1'b1, "R8", "busIdle after cycle", busIdle, 1);
    reqValid = 1'b0;
  endtask

  initial begin
    int unsigned s;
    s = $urandom(32'd20240611);
    rdy = 1'b1;
    repeat (3) @(negedge clk);
    chk({ale, adOe, rdN, wrN, busIdle, doneValid} == 6'b001110, "R1", "reset pins",
        {ale, adOe, rdN, wrN, busIdle, doneValid}, 6'b001110);
    rstN = 1'b1;
    @(negedge clk); @(negedge clk);
    chk({ale, adOe, rdN, wrN, busIdle, doneValid} == 6'b001110, "R1", "idle after reset",
        {ale, adOe, rdN, wrN, busIdle, doneValid}, 6'b001110);

    runCycle(1'b0, 1'b1, 16'h12c4, 8'h00, 8'h3e, 0, 1'b0);   // fetch, no wait (R9, R10)
    runCycle(1'b1, 1'b0, 16'hfe01, 8'ha7, 8'h00, 3, 1'b0);   // write, 3 waits (R5, R6)
    runCycle(1'b1, 1'b1, 16'h8000, 8'h55, 8'h00, 0, 1'b0);   // write wins over fetch (R9)
    runCycle(1'b0, 1'b0, 16'h00ff, 8'h00, 8'hc3, 1, 1'b1);   // read with request while busy (R8)
    @(negedge clk);
    chk(ale == 1'b0 && busIdle == 1'b1, "R8", "busy request ignored", {ale, busIdle}, 2'b01);
    chk(doneValid == 1'b0, "R7", "done is one clock", doneValid, 0);

    for (int n = 0; n < 40; n++) begin
      runCycle($urandom_range(1, 0) == 1, $urandom_range(1, 0) == 1,
               16'($urandom), 8'($urandom), 8'($urandom),
               $urandom_range(4, 0), $urandom_range(3, 0) == 0);
    end

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

endmodule